// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block sits between a simple processor and a set of I/O device slots and decides which device is serviced next. Each slot keeps its own pending flag, which a one-cycle device event sets. The slots are split into priority groups. Inside a group they share one request line, and the acknowledge runs through them in series. The slot nearest the processor that has a request pending stops the acknowledge and places its vector code on the shared vector bus. Slots further down the chain never see the acknowledge.

The processor side holds a small status word: an interrupt-enable bit and a priority level. A group is eligible only when interrupts are enabled and the group's level is strictly above the current level. The controller waits for the processor's ready signal before it raises an acknowledge, and it latches the vector in the following cycle. When it accepts an interrupt, it saves the status word, clears the enable bit and raises the level to that of the serviced group. A return strobe restores the saved word. Software may also load the status word directly, which is how nesting is allowed.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, the interrupt-enable bit is 0, the priority level is 0, every slot pending flag is 0, `inta` is all zero and `vec_valid` is 0.
- R2: A one-cycle pulse on `dev_event[s]` sets pending flag `s` at that clock edge, and the shared request `intr` rises with it. The flag stays set until that slot's vector is taken.
- R3: Slot `s` belongs to group `s / SLOTS_PER_GROUP`, and group `g` has level `NUM_GROUPS - g`, so group 0 ranks highest. A request is acknowledged only while the enable bit is 1 and its group's level is strictly greater than the priority level. A masked request keeps its pending flag.
- R4: `inta` is never raised while `cpu_ready` is low. A request waits as long as it takes, and the acknowledge follows in the cycle after `cpu_ready` is seen high.
- R5: `inta` is one-hot with one bit per group, lasts exactly one cycle, and goes to the eligible group with the highest level.
- R6: Within the acknowledged group, the pending slot with the lowest position wins. Slot `s` supplies `dev_vec[s*VEC_W +: VEC_W]`.
- R7: In the cycle after `inta`, `vec_valid` is high for one cycle and `vec_out` holds the winner's vector. Only the winner's pending flag is cleared.
- R8: On acceptance, the enable bit becomes 0, the priority level becomes the serviced group's level, and the previous enable bit and level are saved. No new `inta` occurs until the enable bit is set again.
- R9: A pulse on `irq_ret` restores the saved enable bit and level.
- R10: A pulse on `stat_wr` loads `stat_ie_in` and `stat_prio_in` into the status word. If `irq_ret` is pulsed in the same cycle, `irq_ret` takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_event | input | NUM_GROUPS*SLOTS_PER_GROUP | Per-slot request event pulses |
| dev_vec | input | NUM_GROUPS*SLOTS_PER_GROUP*VEC_W | Per-slot vector codes |
| cpu_ready | input | 1 | Processor can take a vector now |
| stat_wr | input | 1 | Load the status word |
| stat_ie_in | input | 1 | Enable bit to load |
| stat_prio_in | input | PRIO_W | Priority level to load |
| irq_ret | input | 1 | Return from service; restores the saved status |
| intr | output | 1 | OR of all pending slots |
| inta | output | NUM_GROUPS | Per-group acknowledge into each chain |
| vec_valid | output | 1 | Latched vector is valid this cycle |
| vec_out | output | VEC_W | Latched vector |
| stat_ie | output | 1 | Current enable bit |
| stat_prio | output | PRIO_W | Current priority level |
| dev_pending | output | NUM_GROUPS*SLOTS_PER_GROUP | Slot pending flags |

## Verification
A stale pending flag or a broken chain link shows up at `vec_out` two cycles after the acknowledge. The wrong vector appears there, or the slot that should remain pending clears. A wrong group choice or a wrong masking decision appears on `inta` within three cycles of the request. A status word that is not updated appears on `stat_ie` or `stat_prio` in the cycle after `vec_valid`, and again as an unexpected second acknowledge.

// File: rtl/irq_chain_pkg.sv
// Shared types for the daisy-chained interrupt controller.
// Assumes nothing beyond IEEE 1800-2017.
package irq_chain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT    = 2'd1,
        ST_ACK     = 2'd2,
        ST_CAPTURE = 2'd3
    } irq_state_t;
endpackage

// File: rtl/irq_chain_group.sv
// One priority group: per-slot pending flags and a serial acknowledge chain.
// Position 0 is nearest the processor. Assumes ack_in is high for one cycle
// at most and only while the group requests.
module irq_chain_group #(
    parameter int SLOTS = 2,
    parameter int VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLOTS-1:0]   ev,
    input  logic [SLOTS*VEC_W-1:0] vec_in,
    input  logic               ack_in,
    output logic [SLOTS-1:0]   pend_o,
    output logic               req_o,
    output logic [VEC_W-1:0]   vec_o
);
    logic [SLOTS-1:0] pend_q;
    logic [SLOTS-1:0] pass;
    logic [SLOTS-1:0] grant;

    // Acknowledge ripple: a pending slot blocks, an idle slot forwards.
    assign pass[0] = ack_in;
    genvar k;
    generate
        for (k = 0; k < SLOTS; k++) begin : g_link
            assign grant[k] = pass[k] & pend_q[k];
            if (k < SLOTS - 1) begin : g_fwd
                assign pass[k+1] = pass[k] & ~pend_q[k];
            end
        end
    endgenerate

    // Pending flags: set by event, cleared when granted (a new event wins).
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ev | (pend_q & ~grant);
    end

    // Vector bus: only the granted slot drives a non-zero contribution.
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < SLOTS; i++)
            if (grant[i]) vec_o = vec_o | vec_in[i*VEC_W +: VEC_W];
    end

    assign pend_o = pend_q;
    assign req_o  = |pend_q;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_CLEAR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0 && $past(rst_n) && ($past(pend_q) & ~pend_q) != '0) |-> $past(ack_in)); // R7
endmodule

// File: rtl/irq_status_fsm.sv
// Processor side: status word (enable bit and level), acceptance sequencer
// IDLE -> WAIT -> ACK -> CAPTURE, vector latch and save/restore on return.
// Assumes group g has level NUM_GROUPS-g and NUM_GROUPS < 2**PRIO_W.
module irq_status_fsm
    import irq_chain_pkg::*;
#(
    parameter int NUM_GROUPS = 3,
    parameter int PRIO_W     = 2,
    parameter int VEC_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] grp_req,
    input  logic [VEC_W-1:0]      vec_bus,
    input  logic                  cpu_ready,
    input  logic                  stat_wr,
    input  logic                  ie_in,
    input  logic [PRIO_W-1:0]     prio_in,
    input  logic                  irq_ret,
    output logic [NUM_GROUPS-1:0] inta,
    output logic                  vec_valid,
    output logic [VEC_W-1:0]      vec_out,
    output logic                  ie,
    output logic [PRIO_W-1:0]     prio
);
    irq_state_t state_q, state_d;
    logic ie_q, ie_sv_q;
    logic [PRIO_W-1:0] prio_q, prio_sv_q;
    logic [NUM_GROUPS-1:0] sel_d, sel_q;
    logic [PRIO_W-1:0] sel_lvl;
    logic [VEC_W-1:0] vec_q;
    logic any_elig;

    // Pick the eligible group with the highest level (lowest index).
    always_comb begin
        sel_d = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--)
            if (grp_req[g] && (PRIO_W'(NUM_GROUPS - g) > prio_q)) begin
                sel_d    = '0;
                sel_d[g] = 1'b1;
            end
        any_elig = ie_q && (sel_d != '0);
    end

    // Level of the latched group.
    always_comb begin
        sel_lvl = '0;
        for (int g = 0; g < NUM_GROUPS; g++)
            if (sel_q[g]) sel_lvl = PRIO_W'(NUM_GROUPS - g);
    end

    // Next-state logic of the acceptance sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (any_elig) state_d = ST_WAIT;
            ST_WAIT:    if (!any_elig) state_d = ST_IDLE;
                        else if (cpu_ready) state_d = ST_ACK;
            ST_ACK:     state_d = ST_CAPTURE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State, group select and vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT) sel_q <= sel_d;
            if (state_q == ST_ACK)  vec_q <= vec_bus;
        end
    end

    // Status word: acceptance beats return, return beats software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q      <= 1'b0;
            prio_q    <= '0;
            ie_sv_q   <= 1'b0;
            prio_sv_q <= '0;
        end else if (state_q == ST_ACK) begin
            ie_sv_q   <= ie_q;
            prio_sv_q <= prio_q;
            ie_q      <= 1'b0;
            prio_q    <= sel_lvl;
        end else if (irq_ret) begin
            ie_q   <= ie_sv_q;
            prio_q <= prio_sv_q;
        end else if (stat_wr) begin
            ie_q   <= ie_in;
            prio_q <= prio_in;
        end
    end

    assign inta      = (state_q == ST_ACK) ? sel_q : '0;
    assign vec_valid = (state_q == ST_CAPTURE);
    assign vec_out   = vec_q;
    assign ie        = ie_q;
    assign prio      = prio_q;

    AST_INTA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inta)); // R5
    AST_INTA_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|inta) |-> $past(cpu_ready)); // R4
    AST_INTA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|inta) |=> !(|inta)); // R5
    AST_INTA_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|inta) |-> (sel_lvl > $past(prio_q) && $past(ie_q))); // R3
    AST_VALID_AFTER_INTA: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(|inta)); // R7
    AST_IE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !ie_q); // R8
endmodule

// File: rtl/irq_chain_ctrl.sv
// Top: groups of daisy-chained device slots plus the processor-side sequencer.
// Slot s sits in group s/SLOTS_PER_GROUP at position s%SLOTS_PER_GROUP.
// Assumes NUM_GROUPS < 2**PRIO_W.
module irq_chain_ctrl #(
    parameter int NUM_GROUPS      = 3,
    parameter int SLOTS_PER_GROUP = 2,
    parameter int VEC_W           = 8,
    parameter int PRIO_W          = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic [NUM_GROUPS*SLOTS_PER_GROUP-1:0] dev_event,
    input  logic [NUM_GROUPS*SLOTS_PER_GROUP*VEC_W-1:0] dev_vec,
    input  logic cpu_ready,
    input  logic stat_wr,
    input  logic stat_ie_in,
    input  logic [PRIO_W-1:0] stat_prio_in,
    input  logic irq_ret,
    output logic intr,
    output logic [NUM_GROUPS-1:0] inta,
    output logic vec_valid,
    output logic [VEC_W-1:0] vec_out,
    output logic stat_ie,
    output logic [PRIO_W-1:0] stat_prio,
    output logic [NUM_GROUPS*SLOTS_PER_GROUP-1:0] dev_pending
);
    localparam int NSLOT = NUM_GROUPS * SLOTS_PER_GROUP;
    localparam int GVW   = SLOTS_PER_GROUP * VEC_W;

    logic [NUM_GROUPS-1:0] grp_req;
    logic [VEC_W-1:0] grp_vec [NUM_GROUPS];
    logic [VEC_W-1:0] vec_bus;

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
            irq_chain_group #(.SLOTS(SLOTS_PER_GROUP), .VEC_W(VEC_W)) u_grp (
                .clk    (clk),
                .rst_n  (rst_n),
                .ev     (dev_event[g*SLOTS_PER_GROUP +: SLOTS_PER_GROUP]),
                .vec_in (dev_vec[g*GVW +: GVW]),
                .ack_in (inta[g]),
                .pend_o (dev_pending[g*SLOTS_PER_GROUP +: SLOTS_PER_GROUP]),
                .req_o  (grp_req[g]),
                .vec_o  (grp_vec[g])
            );
        end
    endgenerate

    // Shared vector bus: OR of all group contributions.
    always_comb begin
        vec_bus = '0;
        for (int i = 0; i < NUM_GROUPS; i++) vec_bus = vec_bus | grp_vec[i];
    end

    irq_status_fsm #(.NUM_GROUPS(NUM_GROUPS), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_req   (grp_req),
        .vec_bus   (vec_bus),
        .cpu_ready (cpu_ready),
        .stat_wr   (stat_wr),
        .ie_in     (stat_ie_in),
        .prio_in   (stat_prio_in),
        .irq_ret   (irq_ret),
        .inta      (inta),
        .vec_valid (vec_valid),
        .vec_out   (vec_out),
        .ie        (stat_ie),
        .prio      (stat_prio)
    );

    assign intr = |dev_pending;

    AST_INTR_TRACKS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (|$past(dev_event) && $past(rst_n)) |-> intr); // R2
    AST_PENDING_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(|inta)) |-> ((($past(dev_pending) & ~dev_pending)) == '0)); // R2
    AST_SLOT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(inta) <= 1 && NSLOT > 0); // R5
endmodule

// File: tb/irq_chain_ctrl_tb.sv
// Directed bench: one task per scenario, each checks its own results.
module irq_chain_ctrl_tb;
    localparam int NG = 3, SP = 2, VW = 8, PW = 2, NS = NG * SP;

    logic clk = 0, rst_n = 0;
    logic [NS-1:0] dev_event = '0;
    logic [NS*VW-1:0] dev_vec;
    logic cpu_ready = 1, stat_wr = 0, stat_ie_in = 0, irq_ret = 0;
    logic [PW-1:0] stat_prio_in = '0;
    logic intr, vec_valid, stat_ie;
    logic [NG-1:0] inta;
    logic [VW-1:0] vec_out;
    logic [PW-1:0] stat_prio;
    logic [NS-1:0] dev_pending;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    irq_chain_ctrl #(.NUM_GROUPS(NG), .SLOTS_PER_GROUP(SP), .VEC_W(VW), .PRIO_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_event(dev_event), .dev_vec(dev_vec),
        .cpu_ready(cpu_ready), .stat_wr(stat_wr), .stat_ie_in(stat_ie_in),
        .stat_prio_in(stat_prio_in), .irq_ret(irq_ret), .intr(intr), .inta(inta),
        .vec_valid(vec_valid), .vec_out(vec_out), .stat_ie(stat_ie),
        .stat_prio(stat_prio), .dev_pending(dev_pending));

    always_comb for (int s = 0; s < NS; s++) dev_vec[s*VW +: VW] = VW'(8'hA0 + s);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_event(input logic [NS-1:0] m);
        @(negedge clk); dev_event = m;
        @(negedge clk); dev_event = '0;
    endtask

    task automatic write_stat(input logic ie_v, input logic [PW-1:0] p);
        @(negedge clk); stat_wr = 1; stat_ie_in = ie_v; stat_prio_in = p;
        @(negedge clk); stat_wr = 0;
    endtask

    task automatic do_ret();
        irq_ret = 1;
        @(negedge clk); irq_ret = 0;
    endtask

    // Poll until vec_valid; returns last acknowledge seen. Ends at a negedge.
    task automatic wait_accept(output bit got, output logic [NG-1:0] ack_seen);
        got = 0; ack_seen = '0;
        for (int i = 0; i < 12 && !got; i++) begin
            if (inta != '0) ack_seen = inta;
            if (vec_valid) got = 1;
            else @(negedge clk);
        end
    endtask

    // Watch a window for any acknowledge.
    task automatic no_ack(input int n, input string req);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (inta != '0 || vec_valid) seen = 1;
        end
        chk(!seen, req, int'(seen), 0);
    endtask

    task automatic t_reset();
        chk(stat_ie == 0 && stat_prio == 0, "R1 status", {stat_ie, stat_prio}, 0);
        chk(dev_pending == 0 && inta == 0 && !vec_valid && !intr, "R1 outputs",
            {dev_pending, inta, vec_valid}, 0);
    endtask

    task automatic t_single();
        bit got; logic [NG-1:0] a;
        write_stat(1, 0);
        pulse_event(6'b000010);
        chk(dev_pending[1] && intr, "R2 pending set", dev_pending, 2);
        wait_accept(got, a);
        chk(got && vec_out == 8'hA1, "R7 vector slot1", vec_out, 8'hA1);
        chk(a == 3'b001, "R5 group0 acked", a, 1);
        chk(dev_pending == 0, "R7 winner cleared", dev_pending, 0);
        @(negedge clk);
        chk(!stat_ie && stat_prio == 3, "R8 status on accept", {stat_ie, stat_prio}, 3);
        do_ret();
        chk(stat_ie && stat_prio == 0, "R9 restored", {stat_ie, stat_prio}, 4);
    endtask

    task automatic t_ready();
        bit got; logic [NG-1:0] a;
        cpu_ready = 0;
        pulse_event(6'b001000);
        no_ack(8, "R4 no ack while not ready");
        chk(dev_pending[3], "R4 request waits", dev_pending, 8);
        cpu_ready = 1;
        wait_accept(got, a);
        chk(got && vec_out == 8'hA3 && a == 3'b010, "R4 accept after ready", {a, vec_out}, {3'b010, 8'hA3});
        do_ret();
    endtask

    task automatic t_chain();
        bit got; logic [NG-1:0] a;
        pulse_event(6'b110000);
        wait_accept(got, a);
        chk(got && vec_out == 8'hA4, "R6 nearest slot wins", vec_out, 8'hA4);
        chk(dev_pending == 6'b100000, "R7 loser kept", dev_pending, 6'b100000);
        no_ack(6, "R8 no reentry while disabled");
        do_ret();
        wait_accept(got, a);
        chk(got && vec_out == 8'hA5, "R6 next slot later", vec_out, 8'hA5);
        do_ret();
    endtask

    task automatic t_groups();
        bit got; logic [NG-1:0] a;
        pulse_event(6'b100100);
        wait_accept(got, a);
        chk(got && vec_out == 8'hA2 && a == 3'b010, "R5 higher group first", {a, vec_out}, {3'b010, 8'hA2});
        @(negedge clk);
        write_stat(1, 2);
        no_ack(6, "R3 lower group masked at level 2");
        chk(dev_pending[5], "R3 masked stays pending", dev_pending, 6'b100000);
        do_ret();
        wait_accept(got, a);
        chk(got && vec_out == 8'hA5 && a == 3'b100, "R9 resume group2", {a, vec_out}, {3'b100, 8'hA5});
        do_ret();
    endtask

    task automatic t_mask();
        bit got; logic [NG-1:0] a;
        write_stat(1, 2);
        pulse_event(6'b001000);
        no_ack(6, "R3 level2 group masked");
        pulse_event(6'b000001);
        wait_accept(got, a);
        chk(got && vec_out == 8'hA0, "R3 level3 accepted", vec_out, 8'hA0);
        @(negedge clk);
        do_ret();
        chk(stat_ie && stat_prio == 2, "R9 level restored", {stat_ie, stat_prio}, 6);
        no_ack(4, "R3 still masked after return");
        write_stat(1, 1);
        wait_accept(got, a);
        chk(got && vec_out == 8'hA3, "R10 lowered level admits", vec_out, 8'hA3);
        @(negedge clk);
        // Saved word is ie=1, level=1; return must beat the write.
        irq_ret = 1; stat_wr = 1; stat_ie_in = 0; stat_prio_in = 3;
        @(negedge clk); irq_ret = 0; stat_wr = 0;
        chk(stat_ie && stat_prio == 1, "R10 return beats write", {stat_ie, stat_prio}, 5);
    endtask

    task automatic t_disabled();
        bit got; logic [NG-1:0] a;
        write_stat(0, 0);
        pulse_event(6'b000001);
        no_ack(6, "R3 disabled blocks");
        chk(dev_pending[0], "R3 pending kept while disabled", dev_pending, 1);
        write_stat(1, 0);
        wait_accept(got, a);
        chk(got && vec_out == 8'hA0, "R10 enable write admits", vec_out, 8'hA0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single();
        t_ready();
        t_chain();
        t_groups();
        t_mask();
        t_disabled();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++; fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule